// File: doc/BRIEF.md
# Periodic Tap Interval Timer

This block raises a periodic exception by watching one bit of a free-running 32-bit time-base counter. The counter advances by one on every tick strobe and wraps modulo 2^32. Software can also load it through a write port. A 2-bit period selector picks one of four tap bits: 20, 16, 12 or 8. The selected bit goes from 0 to 1 once every 2^21, 2^17, 2^13 or 2^9 ticks respectively. Each 0-to-1 change of the tapped bit is an exception. This includes a change caused by a software load.

The edge is found by comparing the tapped bit of the current count with the same bit of the value about to be stored. Both sides use the same selector value, so a write and a tick are judged alike. Changing the selector alone never creates an edge.

An exception moves a two-state status machine from QUIET to PENDING. The transition out of QUIET to PENDING is called *raise* and fires on an edge. PENDING stays in PENDING while no acknowledge arrives or while a new edge lands in the same cycle. PENDING returns to QUIET through the *ack* transition, which happens when a write-one acknowledge arrives with no edge in that cycle. QUIET stays in QUIET while no edge occurs. The interrupt line is the pending flag gated by an enable input.

Top module: `periodic_tap_timer`

## Requirements
- R1: After reset the count `tb_o` is 0, `pending_o` is 0 and `irq_o` is 0.
- R2: With `tick_i`=1 and `tb_wr_i`=0, `tb_o` becomes the old value plus one modulo 2^32 at the next clock edge. With both inputs at 0, `tb_o` holds.
- R3: With `tb_wr_i`=1, `tb_o` takes `tb_wdata_i` at the next edge. A write in the same cycle as a tick wins, and the tick is dropped.
- R4: `period_sel_i` selects the tap bit as follows: 2'b00 gives bit 20 (period 2^21 ticks), 2'b01 gives bit 16 (2^17), 2'b10 gives bit 12 (2^13) and 2'b11 gives bit 8 (2^9). Edges on bits that are not selected are ignored.
- R5: When counting takes the tapped bit from 0 to 1, `pending_o` is 1 from the next clock edge, together with the new count. A 1-to-0 change of the tapped bit raises nothing. Continuous counting gives one exception per period.
- R6: A write that takes the tapped bit from 0 to 1 raises the exception exactly as counting does.
- R7: A change of `period_sel_i` with no tick and no write never raises an exception, even when the newly tapped bit is 1.
- R8: `pending_o` is sticky. It clears at the next edge only when `ack_wr_i`=1 and `ack_data_i`=1. An acknowledge write with `ack_data_i`=0 has no effect.
- R9: If an exception and a clearing acknowledge fall in the same cycle, `pending_o` stays 1.
- R10: `irq_o` equals `pending_o` AND `irq_en_i`, and follows `irq_en_i` without a clock delay.
- R11: The wrap from 32'hFFFFFFFF to 0 raises no exception on any tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Time-base advance strobe |
| tb_wr_i | input | 1 | Time-base load strobe |
| tb_wdata_i | input | 32 | Value loaded into the time base |
| period_sel_i | input | 2 | Tap selector (period choice) |
| irq_en_i | input | 1 | Interrupt enable |
| ack_wr_i | input | 1 | Status write strobe |
| ack_data_i | input | 1 | Status write data; 1 clears |
| tb_o | output | 32 | Current time-base count |
| pending_o | output | 1 | Sticky exception status |
| irq_o | output | 1 | Gated interrupt request |

## Verification
Two pairs of functions can coincide in one cycle. The first pair is a time-base load and a tick. It is provoked by asserting both strobes together while the write value moves the tapped bit from 0 to 1. The bench then expects the written value with no increment, and it expects the exception. The second pair is an edge and a clearing acknowledge. It is provoked by ticking across a tap boundary while writing 1 to the status. The scoreboard model then expects `pending_o` to stay set.

// File: rtl/ptt_pkg.sv
package ptt_pkg;

    typedef enum logic {
        PS_QUIET   = 1'b0,
        PS_PENDING = 1'b1
    } pend_state_e;

    function automatic int unsigned ptt_tap_bit(input int unsigned sel,
                                                input int unsigned hi,
                                                input int unsigned step);
        return hi - sel * step;
    endfunction

endpackage

// File: rtl/ptt_timebase.sv
module ptt_timebase #(
    parameter int unsigned TB_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            wr_i,
    input  logic [TB_W-1:0] wdata_i,
    output logic [TB_W-1:0] tb_q_o,
    output logic [TB_W-1:0] tb_nxt_o
);

    logic [TB_W-1:0] tb_q;

    always_comb begin
        if (wr_i) begin
            tb_nxt_o = wdata_i;
        end else if (tick_i) begin
            tb_nxt_o = tb_q + 1'b1;
        end else begin
            tb_nxt_o = tb_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tb_q <= '0;
        end else begin
            tb_q <= tb_nxt_o;
        end
    end

    assign tb_q_o = tb_q;

    // R2
    tb_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !wr_i) |=> (tb_q == $past(tb_q) + 1'b1));

    // R2
    tb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_i) |=> $stable(tb_q));

    // R3
    tb_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (tb_q == $past(wdata_i)));

endmodule

// File: rtl/ptt_tap_edge.sv
module ptt_tap_edge
    import ptt_pkg::*;
#(
    parameter int unsigned TB_W     = 32,
    parameter int unsigned SEL_W    = 2,
    parameter int unsigned TAP_HI   = 20,
    parameter int unsigned TAP_STEP = 4
) (
    input  logic [TB_W-1:0]  tb_cur_i,
    input  logic [TB_W-1:0]  tb_nxt_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             hit_o
);

    localparam int unsigned N_TAPS = 1 << SEL_W;

    logic [N_TAPS-1:0] rise;

    for (genvar t = 0; t < N_TAPS; t++) begin : g_tap
        localparam int unsigned BITPOS = ptt_tap_bit(t, TAP_HI, TAP_STEP);
        assign rise[t] = !tb_cur_i[BITPOS] && tb_nxt_i[BITPOS];
    end

    assign hit_o = rise[sel_i];

endmodule

// File: rtl/ptt_status_fsm.sv
module ptt_status_fsm
    import ptt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic ack_wr_i,
    input  logic ack_data_i,
    input  logic irq_en_i,
    output logic pending_o,
    output logic irq_o
);

    pend_state_e state_q, state_d;
    logic        ack;

    assign ack = ack_wr_i && ack_data_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_QUIET:   state_d = hit_i ? PS_PENDING : PS_QUIET;
            PS_PENDING: state_d = (ack && !hit_i) ? PS_QUIET : PS_PENDING;
            default:    state_d = PS_QUIET;
        endcase
    end

    always_comb begin
        pending_o = (state_q == PS_PENDING);
        irq_o     = pending_o && irq_en_i;
    end

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && !ack) |=> pending_o);

    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !hit_i) |=> !pending_o);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_i |-> !irq_o);

endmodule

// File: rtl/periodic_tap_timer.sv
module periodic_tap_timer
    import ptt_pkg::*;
#(
    parameter int unsigned TB_W     = 32,
    parameter int unsigned SEL_W    = 2,
    parameter int unsigned TAP_HI   = 20,
    parameter int unsigned TAP_STEP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             tb_wr_i,
    input  logic [TB_W-1:0]  tb_wdata_i,
    input  logic [SEL_W-1:0] period_sel_i,
    input  logic             irq_en_i,
    input  logic             ack_wr_i,
    input  logic             ack_data_i,
    output logic [TB_W-1:0]  tb_o,
    output logic             pending_o,
    output logic             irq_o
);

    logic [TB_W-1:0] tb_nxt;
    logic            hit;

    ptt_timebase #(.TB_W(TB_W)) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .wr_i     (tb_wr_i),
        .wdata_i  (tb_wdata_i),
        .tb_q_o   (tb_o),
        .tb_nxt_o (tb_nxt)
    );

    ptt_tap_edge #(
        .TB_W     (TB_W),
        .SEL_W    (SEL_W),
        .TAP_HI   (TAP_HI),
        .TAP_STEP (TAP_STEP)
    ) u_tap_edge (
        .tb_cur_i (tb_o),
        .tb_nxt_i (tb_nxt),
        .sel_i    (period_sel_i),
        .hit_o    (hit)
    );

    ptt_status_fsm u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (hit),
        .ack_wr_i   (ack_wr_i),
        .ack_data_i (ack_data_i),
        .irq_en_i   (irq_en_i),
        .pending_o  (pending_o),
        .irq_o      (irq_o)
    );

    // R5
    hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> pending_o);

    // R9
    hit_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ack_wr_i && ack_data_i) |=> pending_o);

    // R7
    reselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !tb_wr_i) |-> !hit);

    // R11
    wrap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !tb_wr_i && (&tb_o)) |-> !hit);

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!pending_o && !irq_o);
        end
    end

endmodule

// File: tb/periodic_tap_timer_bench.sv
`timescale 1ns/1ps
module periodic_tap_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        tb_wr_i = 1'b0;
    logic [31:0] tb_wdata_i = '0;
    logic [1:0]  period_sel_i = '0;
    logic        irq_en_i = 1'b0;
    logic        ack_wr_i = 1'b0;
    logic        ack_data_i = 1'b0;
    logic [31:0] tb_o;
    logic        pending_o;
    logic        irq_o;

    always #2 clk = ~clk;

    periodic_tap_timer u_periodic_tap_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .tb_wr_i      (tb_wr_i),
        .tb_wdata_i   (tb_wdata_i),
        .period_sel_i (period_sel_i),
        .irq_en_i     (irq_en_i),
        .ack_wr_i     (ack_wr_i),
        .ack_data_i   (ack_data_i),
        .tb_o         (tb_o),
        .pending_o    (pending_o),
        .irq_o        (irq_o)
    );

    int checks = 0;
    int failures = 0;
    int pend_seen = 0;
    bit done = 1'b0;

    logic [31:0] q_tb[$];
    logic        q_st[$];
    logic        q_irq[$];
    string       q_req[$];

    logic [31:0] mdl_tb = '0;
    logic        mdl_st = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic tk, input logic wr, input logic [31:0] wd,
                        input logic [1:0] sel, input logic en,
                        input logic aw, input logic ad, input string req);
        logic [31:0] nxt;
        int unsigned bitpos;
        logic hit;
        @(negedge clk);
        tick_i = tk; tb_wr_i = wr; tb_wdata_i = wd; period_sel_i = sel;
        irq_en_i = en; ack_wr_i = aw; ack_data_i = ad;
        nxt = wr ? wd : (tk ? mdl_tb + 32'd1 : mdl_tb);
        bitpos = 20 - 4 * int'(sel);
        hit = !mdl_tb[bitpos] && nxt[bitpos];
        mdl_st = hit || (mdl_st && !(aw && ad));
        mdl_tb = nxt;
        q_tb.push_back(mdl_tb);
        q_st.push_back(mdl_st);
        q_irq.push_back(mdl_st && en);
        q_req.push_back(req);
    endtask

    task automatic idle(input logic [1:0] sel, input logic en, input string req);
        step(1'b0, 1'b0, 32'h0, sel, en, 1'b0, 1'b0, req);
    endtask

    task automatic clear(input logic [1:0] sel, input string req);
        step(1'b0, 1'b0, 32'h0, sel, 1'b0, 1'b1, 1'b1, req);
    endtask

    // monitor: pop and compare after each rising edge
    always begin
        @(posedge clk);
        #1;
        if (q_tb.size() > 0) begin
            logic [31:0] etb;
            logic est, eirq;
            string req;
            etb = q_tb.pop_front();
            est = q_st.pop_front();
            eirq = q_irq.pop_front();
            req = q_req.pop_front();
            check(tb_o === etb, req, "tb_o", tb_o, etb);
            check(pending_o === est, req, "pending_o", {31'd0, pending_o}, {31'd0, est});
            check(irq_o === eirq, req, "irq_o", {31'd0, irq_o}, {31'd0, eirq});
            if (pending_o === 1'b1) pend_seen++;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(tb_o === 32'h0, "R1", "tb_o", tb_o, 32'h0);
        check(pending_o === 1'b0, "R1", "pending_o", {31'd0, pending_o}, 32'h0);
        check(irq_o === 1'b0, "R1", "irq_o", {31'd0, irq_o}, 32'h0);
        rst_n = 1'b1;

        // R2 hold and count
        idle(2'b11, 1'b1, "R2");
        repeat (5) step(1'b1, 1'b0, 32'h0, 2'b11, 1'b1, 1'b0, 1'b0, "R2");
        idle(2'b11, 1'b1, "R2");

        // R5 counting edge on bit 8, irq enabled (R10)
        step(1'b0, 1'b1, 32'h0000_00FE, 2'b11, 1'b1, 1'b0, 1'b0, "R3");
        step(1'b1, 1'b0, 32'h0, 2'b11, 1'b1, 1'b0, 1'b0, "R5");
        step(1'b1, 1'b0, 32'h0, 2'b11, 1'b1, 1'b0, 1'b0, "R5");
        idle(2'b11, 1'b0, "R10");
        idle(2'b11, 1'b1, "R10");
        // R8 write of 0 ignored, write of 1 clears
        step(1'b0, 1'b0, 32'h0, 2'b11, 1'b1, 1'b1, 1'b0, "R8");
        idle(2'b11, 1'b1, "R8");
        clear(2'b11, "R8");
        idle(2'b11, 1'b1, "R8");
        // R5 falling change of tap bit raises nothing
        step(1'b0, 1'b1, 32'h0000_01FF, 2'b11, 1'b1, 1'b0, 1'b0, "R5");
        step(1'b1, 1'b0, 32'h0, 2'b11, 1'b1, 1'b0, 1'b0, "R5");
        idle(2'b11, 1'b1, "R5");

        // R6 write creating a rising tap bit
        step(1'b0, 1'b1, 32'h0000_0000, 2'b11, 1'b1, 1'b0, 1'b0, "R6");
        step(1'b0, 1'b1, 32'h0000_0100, 2'b11, 1'b1, 1'b0, 1'b0, "R6");
        idle(2'b11, 1'b1, "R6");
        clear(2'b11, "R6");

        // R4 each selector: its own tap rises, other taps are ignored
        for (int s = 0; s < 4; s++) begin
            for (int o = 0; o < 4; o++) begin
                logic [31:0] pre;
                pre = (32'd1 << (20 - 4 * o)) - 32'd1;
                step(1'b0, 1'b1, pre, s[1:0], 1'b0, 1'b1, 1'b1, "R4");
                step(1'b1, 1'b0, 32'h0, s[1:0], 1'b0, 1'b0, 1'b0, "R4");
                idle(s[1:0], 1'b0, "R4");
            end
        end
        clear(2'b00, "R4");

        // R7 reselection onto a bit that is already 1
        step(1'b0, 1'b1, 32'h0000_0100, 2'b00, 1'b0, 1'b1, 1'b1, "R7");
        idle(2'b00, 1'b0, "R7");
        idle(2'b11, 1'b0, "R7");
        idle(2'b11, 1'b0, "R7");
        step(1'b0, 1'b1, 32'h0010_1000, 2'b11, 1'b0, 1'b0, 1'b0, "R7");
        idle(2'b00, 1'b0, "R7");
        idle(2'b10, 1'b0, "R7");

        // R9 edge and clearing acknowledge together
        step(1'b0, 1'b1, 32'h0000_00FF, 2'b11, 1'b1, 1'b1, 1'b1, "R9");
        step(1'b1, 1'b0, 32'h0, 2'b11, 1'b1, 1'b0, 1'b0, "R9");
        step(1'b0, 1'b1, 32'h0000_00FF, 2'b11, 1'b1, 1'b0, 1'b0, "R9");
        step(1'b1, 1'b0, 32'h0, 2'b11, 1'b1, 1'b1, 1'b1, "R9");
        idle(2'b11, 1'b1, "R9");
        clear(2'b11, "R9");

        // R3 write and tick together: write wins, edge from write
        step(1'b0, 1'b1, 32'h0000_0FF0, 2'b10, 1'b1, 1'b0, 1'b0, "R3");
        step(1'b1, 1'b1, 32'h0000_1000, 2'b10, 1'b1, 1'b0, 1'b0, "R3");
        idle(2'b10, 1'b1, "R3");
        clear(2'b10, "R3");

        // R11 wrap raises nothing on any tap
        for (int s = 0; s < 4; s++) begin
            step(1'b0, 1'b1, 32'hFFFF_FFFF, s[1:0], 1'b1, 1'b0, 1'b0, "R11");
            step(1'b1, 1'b0, 32'h0, s[1:0], 1'b1, 1'b0, 1'b0, "R11");
            idle(s[1:0], 1'b1, "R11");
        end

        // R5 periodic: 1100 ticks from 0 on the 2^9 tap with ack every cycle
        step(1'b0, 1'b1, 32'h0, 2'b11, 1'b1, 1'b1, 1'b1, "R5");
        repeat (3) @(negedge clk);
        pend_seen = 0;
        repeat (1100) step(1'b1, 1'b0, 32'h0, 2'b11, 1'b1, 1'b1, 1'b1, "R5");
        idle(2'b11, 1'b1, "R5");
        repeat (3) @(negedge clk);
        check(pend_seen == 2, "R5", "pulses per 1100 ticks",
              32'(pend_seen), 32'd2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule